// File: doc/BRIEF.md
# DMA Instruction Sequencer

This block runs a small instruction program that describes DMA transfers. A start pulse loads the program counter. The block then reads 32-bit words from an instruction memory port. It decodes the opcode in the top nibble of each word, collects the argument words that the opcode needs, and then carries out the instruction.

Instructions are one to four words long:
- **Transfer instructions** become a byte-count/address request on a downstream DMA port. The request is held until that port accepts it.
- **Register-write instructions** drive a one-cycle masked write on a simple register-write port.
- **Jumps** reload the program counter.
- **Flag bits** in the first word can stall the sequencer until an external line-sync event arrives. They can also raise interrupt pulses when the instruction finishes.
- **Undefined opcodes** raise an error pulse and stop the sequencer.

A typical stop program is a register write with the second interrupt flag set, followed by a jump back to that register write. The sequencer then loops there until it is reset.

Top module: `dma_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `dma_valid`, `reg_we`, `irq1`, `irq2` and `irq_err` are all 0.
- R2: A `start` pulse while idle loads `start_pc`. In the next cycle `busy` is 1 and `imem_addr` equals `start_pc`. Each consumed word then advances the counter by one.
- R3: The opcode is word bits [31:28]. The encodings and their lengths in words are:
  - 0x0 sync: 1 word
  - 0x1 transfer: 2 words
  - 0x2 skip: 1 word
  - 0x7 jump: 2 words
  - 0x9 and 0xB transfer with auxiliary word: 3 words
  - 0xD register write: 4 words
  - All other opcodes are undefined.
- R4: A transfer drives a DMA request with these fields:
  - `dma_count` = word bits [11:0]
  - `dma_addr` = second word
  - `dma_sol` = bit 27
  - `dma_eol` = bit 26
  - `dma_aux` = 0
- R5: Opcodes 0x9 and 0xB issue the same request as a transfer, with `dma_aux` equal to the third word.
- R6: While `dma_valid` is 1 and `dma_ready` is 0, the request and all its fields stay unchanged.
- R7: A register write takes its words as address, then value, then mask. It pulses `reg_we` for one cycle with:
  - `reg_addr` = the address word
  - `reg_wmask` = the mask word
  - `reg_wdata` = value AND mask
- R8: A jump loads its second word into the program counter. The next fetch comes from that address.
- R9: Bit 24 set (`irq1`) or bit 25 set (`irq2`) produces a one-cycle pulse on that output in the cycle after the instruction completes.
- R10: With bit 15 set, the instruction waits after its words are read. It proceeds only in a cycle where `sync_valid` is 1 and `sync_line` equals its bits [11:0].
- R11: An undefined opcode gives a one-cycle `irq_err` pulse, and the block returns to idle.
- R12: `start` has no effect while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin execution at `start_pc` |
| start_pc | input | AW | Program start address (word index) |
| busy | output | 1 | Sequencer is running |
| imem_addr | output | AW | Instruction memory word address |
| imem_rdata | input | 32 | Word at `imem_addr`, same cycle |
| sync_valid | input | 1 | Line-sync event present |
| sync_line | input | 12 | Line number of the sync event |
| dma_valid | output | 1 | DMA request present |
| dma_ready | input | 1 | DMA port accepts request |
| dma_count | output | 12 | Byte count |
| dma_addr | output | 32 | Target address |
| dma_aux | output | 32 | Auxiliary word (0 for plain transfer) |
| dma_sol | output | 1 | Start-of-line marker |
| dma_eol | output | 1 | End-of-line marker |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | 32 | Register address |
| reg_wdata | output | 32 | Masked write value |
| reg_wmask | output | 32 | Bit mask of the write |
| irq1 | output | 1 | First interrupt pulse |
| irq2 | output | 1 | Second interrupt pulse |
| irq_err | output | 1 | Undefined-opcode pulse |

## Verification
The checks assume three things about the inputs:
- Instruction memory answers combinationally for the address currently shown.
- A program never jumps into the middle of a multi-word instruction.
- `dma_ready` is a plain level that the downstream side may hold low for any number of cycles.

The stimulus keeps to these assumptions. Programs are laid out whole in a word array, and every jump targets the first word of an instruction. Back-pressure and sync events are driven only between clock edges. Mismatched sync line numbers are shown before the matching one to prove that the stall holds.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    localparam int WORDW = 32;
    localparam int CNTW  = 12;

    localparam logic [3:0] OP_SYNC = 4'h0;
    localparam logic [3:0] OP_XFER = 4'h1;
    localparam logic [3:0] OP_SKIP = 4'h2;
    localparam logic [3:0] OP_JUMP = 4'h7;
    localparam logic [3:0] OP_XFA  = 4'h9;
    localparam logic [3:0] OP_XFB  = 4'hB;
    localparam logic [3:0] OP_WREG = 4'hD;

    localparam int BIT_RESYNC = 15;
    localparam int BIT_IRQ1   = 24;
    localparam int BIT_IRQ2   = 25;
    localparam int BIT_EOL    = 26;
    localparam int BIT_SOL    = 27;

    typedef enum logic [2:0] {S_IDLE, S_FETCH, S_ARGS, S_RSYNC, S_EXEC} seq_st_e;
    typedef enum logic [2:0] {K_NOP, K_DMA, K_REG, K_JMP, K_BAD} kind_e;
endpackage

// File: rtl/dma_seq_decode.sv
module dma_seq_decode
    import dma_seq_pkg::*;
(
    input  logic [3:0] op,
    output kind_e      kind,
    output logic [1:0] nargs
);
    always_comb begin
        kind  = K_BAD;
        nargs = 2'd0;
        case (op)
            OP_SYNC, OP_SKIP: begin kind = K_NOP; nargs = 2'd0; end
            OP_XFER:          begin kind = K_DMA; nargs = 2'd1; end
            OP_XFA, OP_XFB:   begin kind = K_DMA; nargs = 2'd2; end
            OP_JUMP:          begin kind = K_JMP; nargs = 2'd1; end
            OP_WREG:          begin kind = K_REG; nargs = 2'd3; end
            default:          begin kind = K_BAD; nargs = 2'd0; end
        endcase
    end
endmodule

// File: rtl/dma_seq_irq.sv
module dma_seq_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic flag1,
    input  logic flag2,
    input  logic bad,
    output logic irq1,
    output logic irq2,
    output logic irq_err
);
    typedef struct packed {
        logic p1;
        logic p2;
        logic pe;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d.p1 = done & flag1;
        irq_d.p2 = done & flag2;
        irq_d.pe = bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq1    = irq_q.p1;
    assign irq2    = irq_q.p2;
    assign irq_err = irq_q.pe;
endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_pc,
    output logic          busy,
    output logic [AW-1:0] imem_addr,
    input  logic [31:0]   imem_rdata,
    input  logic          sync_valid,
    input  logic [11:0]   sync_line,
    output logic          dma_valid,
    input  logic          dma_ready,
    output logic [11:0]   dma_count,
    output logic [31:0]   dma_addr,
    output logic [31:0]   dma_aux,
    output logic          dma_sol,
    output logic          dma_eol,
    output logic          reg_we,
    output logic [31:0]   reg_addr,
    output logic [31:0]   reg_wdata,
    output logic [31:0]   reg_wmask,
    output logic          irq1,
    output logic          irq2,
    output logic          irq_err
);
    localparam int NARG = 3;

    typedef struct packed {
        seq_st_e                    st;
        logic [AW-1:0]              pc;
        logic [WORDW-1:0]           ins;
        logic [1:0]                 idx;
        logic [NARG-1:0][WORDW-1:0] arg;
    } seq_t;

    seq_t seq_d, seq_q;

    kind_e      fetch_kind, cur_kind;
    logic [1:0] fetch_nargs, cur_nargs;
    logic       done, bad;

    // Decoder for the incoming word and for the latched instruction
    dma_seq_decode u_dec_fetch (.op(imem_rdata[31:28]), .kind(fetch_kind), .nargs(fetch_nargs));
    dma_seq_decode u_dec_cur   (.op(seq_q.ins[31:28]),  .kind(cur_kind),   .nargs(cur_nargs));

    always_comb begin
        seq_d = seq_q;
        done  = 1'b0;
        bad   = 1'b0;
        case (seq_q.st)
            S_IDLE: begin
                if (start) begin
                    seq_d.st = S_FETCH;
                    seq_d.pc = start_pc;
                end
            end
            S_FETCH: begin
                seq_d.ins = imem_rdata;
                seq_d.pc  = seq_q.pc + 1'b1;
                seq_d.idx = 2'd0;
                if (fetch_kind == K_BAD) begin
                    bad      = 1'b1;
                    seq_d.st = S_IDLE;
                end else if (fetch_nargs != 2'd0) begin
                    seq_d.st = S_ARGS;
                end else if (imem_rdata[BIT_RESYNC]) begin
                    seq_d.st = S_RSYNC;
                end else begin
                    seq_d.st = S_EXEC;
                end
            end
            S_ARGS: begin
                seq_d.arg[seq_q.idx] = imem_rdata;
                seq_d.pc  = seq_q.pc + 1'b1;
                seq_d.idx = seq_q.idx + 2'd1;
                if (seq_q.idx == cur_nargs - 2'd1)
                    seq_d.st = seq_q.ins[BIT_RESYNC] ? S_RSYNC : S_EXEC;
            end
            S_RSYNC: begin
                if (sync_valid && sync_line == seq_q.ins[CNTW-1:0])
                    seq_d.st = S_EXEC;
            end
            S_EXEC: begin
                case (cur_kind)
                    K_DMA: done = dma_ready;
                    K_JMP: begin
                        seq_d.pc = seq_q.arg[0][AW-1:0];
                        done     = 1'b1;
                    end
                    default: done = 1'b1;
                endcase
                if (done) seq_d.st = S_FETCH;
            end
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    dma_seq_irq u_irq (
        .clk(clk), .rst_n(rst_n), .done(done),
        .flag1(seq_q.ins[BIT_IRQ1]), .flag2(seq_q.ins[BIT_IRQ2]), .bad(bad),
        .irq1(irq1), .irq2(irq2), .irq_err(irq_err)
    );

    assign busy      = (seq_q.st != S_IDLE);
    assign imem_addr = seq_q.pc;
    assign dma_valid = (seq_q.st == S_EXEC) && (cur_kind == K_DMA);
    assign dma_count = seq_q.ins[CNTW-1:0];
    assign dma_addr  = seq_q.arg[0];
    assign dma_aux   = (cur_nargs == 2'd2) ? seq_q.arg[1] : '0;
    assign dma_sol   = seq_q.ins[BIT_SOL];
    assign dma_eol   = seq_q.ins[BIT_EOL];
    assign reg_we    = (seq_q.st == S_EXEC) && (cur_kind == K_REG);
    assign reg_addr  = seq_q.arg[0];
    assign reg_wdata = seq_q.arg[1] & seq_q.arg[2];
    assign reg_wmask = seq_q.arg[2];
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        dma_valid,
    input logic        dma_ready,
    input logic [11:0] dma_count,
    input logic [31:0] dma_addr,
    input logic [31:0] dma_aux,
    input logic        reg_we,
    input logic        irq1,
    input logic        irq2,
    input logic        irq_err
);
    // R6
    dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_valid && !dma_ready |=> dma_valid && $stable(dma_count) && $stable(dma_addr) && $stable(dma_aux));

    // R7
    reg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R9
    irq1_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq1 |=> !irq1);

    // R9
    irq2_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq2 |=> !irq2);

    // R11
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> !busy);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dma_valid && !reg_we);
endmodule

bind dma_seq dma_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_count(dma_count),
    .dma_addr(dma_addr), .dma_aux(dma_aux), .reg_we(reg_we),
    .irq1(irq1), .irq2(irq2), .irq_err(irq_err)
);

// File: tb/tb_dma_seq.sv
module tb_dma_seq;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_pc = '0;
    logic          busy;
    logic [AW-1:0] imem_addr;
    logic [31:0]   imem_rdata;
    logic          sync_valid = 1'b0;
    logic [11:0]   sync_line = '0;
    logic          dma_valid;
    logic          dma_ready = 1'b1;
    logic [11:0]   dma_count;
    logic [31:0]   dma_addr, dma_aux;
    logic          dma_sol, dma_eol;
    logic          reg_we;
    logic [31:0]   reg_addr, reg_wdata, reg_wmask;
    logic          irq1, irq2, irq_err;

    logic [31:0] mem [0:(1<<AW)-1];
    assign imem_rdata = mem[imem_addr];

    always #10 clk = ~clk;

    dma_seq #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc), .busy(busy),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .sync_valid(sync_valid), .sync_line(sync_line),
        .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_count(dma_count),
        .dma_addr(dma_addr), .dma_aux(dma_aux), .dma_sol(dma_sol), .dma_eol(dma_eol),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wmask(reg_wmask),
        .irq1(irq1), .irq2(irq2), .irq_err(irq_err)
    );

    localparam int EV_DMA = 1, EV_REG = 2, EV_I1 = 3, EV_I2 = 4, EV_ERR = 5;
    localparam logic [31:0] F_RS = 32'h1 << 15, F_I1 = 32'h1 << 24, F_I2 = 32'h1 << 25,
                            F_EOL = 32'h1 << 26, F_SOL = 32'h1 << 27;

    typedef struct {
        int          kind;
        logic [31:0] a, b, c;
    } ev_t;

    ev_t exp_q[$];
    int  nchk = 0;
    int  nbad = 0;

    function automatic logic [31:0] mk(input logic [3:0] op, input logic [31:0] fl, input logic [11:0] cnt);
        return {op, 28'h0} | fl | {20'h0, cnt};
    endfunction

    function automatic string req_of(input int k);
        case (k)
            EV_DMA:  return "R4/R5";
            EV_REG:  return "R7";
            EV_ERR:  return "R11";
            default: return "R9";
        endcase
    endfunction

    task automatic push(input int k, input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
        ev_t e;
        e.kind = k; e.a = a; e.b = b; e.c = c;
        exp_q.push_back(e);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (act !== expv) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic got(input int k, input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
        ev_t e;
        nchk++;
        if (exp_q.size() == 0) begin
            nbad++;
            $display("FAIL %s unexpected event actual=%0d expected=none", req_of(k), k);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != k || e.a !== a || e.b !== b || e.c !== c) begin
                nbad++;
                $display("FAIL %s actual=%0d/%h/%h/%h expected=%0d/%h/%h/%h",
                         req_of(e.kind), k, a, b, c, e.kind, e.a, e.b, e.c);
            end
        end
    endtask

    // Monitor: samples between edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (dma_valid && dma_ready)
                got(EV_DMA, dma_addr, {18'h0, dma_sol, dma_eol, dma_count}, dma_aux);
            if (reg_we)  got(EV_REG, reg_addr, reg_wdata, reg_wmask);
            if (irq1)    got(EV_I1, 0, 0, 0);
            if (irq2)    got(EV_I2, 0, 0, 0);
            if (irq_err) got(EV_ERR, 0, 0, 0);
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic go(input logic [AW-1:0] pc);
        start_pc = pc;
        start    = 1'b1;
        step();
        start    = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 500 && busy; i++) step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = 32'hF000_0000;

        // Program A: transfers, skip, register write, jump to undefined opcode
        mem[10'h10] = mk(4'h1, F_SOL | F_EOL | F_I1, 12'd64);
        mem[10'h11] = 32'h0000_1000;
        mem[10'h12] = mk(4'h9, F_SOL, 12'd20);
        mem[10'h13] = 32'h0000_2000;
        mem[10'h14] = 32'h0000_00AA;
        mem[10'h15] = mk(4'h2, 0, 12'd0);
        mem[10'h16] = mk(4'hD, F_I2, 12'd0);
        mem[10'h17] = 32'h0000_0040;
        mem[10'h18] = 32'hFFFF_0F0F;
        mem[10'h19] = 32'h00FF_00FF;
        mem[10'h1A] = mk(4'h7, 0, 12'd0);
        mem[10'h1B] = 32'h0000_0030;
        mem[10'h30] = mk(4'hF, 0, 12'd0);

        // Program B: resync on line 5, transfer with aux word, undefined opcode
        mem[10'h50] = mk(4'h0, F_RS, 12'd5);
        mem[10'h51] = mk(4'hB, F_EOL, 12'd8);
        mem[10'h52] = 32'h0000_3000;
        mem[10'h53] = 32'h0000_0055;
        mem[10'h54] = mk(4'hE, 0, 12'd0);

        // Program C: stop loop
        mem[10'h70] = mk(4'hD, F_I2, 12'd0);
        mem[10'h71] = 32'h0000_0044;
        mem[10'h72] = 32'h0000_0001;
        mem[10'h73] = 32'h0000_0001;
        mem[10'h74] = mk(4'h7, 0, 12'd0);
        mem[10'h75] = 32'h0000_0070;

        step(2);
        // R1 reset state
        check("R1", {26'h0, busy, dma_valid, reg_we, irq1, irq2, irq_err}, 32'h0);
        rst_n = 1'b1;
        step(2);
        check("R1", {31'h0, busy}, 32'h0);

        // Program A (R3 R4 R5 R7 R8 R9 R11)
        push(EV_DMA, 32'h1000, 32'h3000 | 32'd64, 32'h0);
        push(EV_I1, 0, 0, 0);
        push(EV_DMA, 32'h2000, 32'h2000 | 32'd20, 32'hAA);
        push(EV_REG, 32'h40, 32'h00FF_000F, 32'h00FF_00FF);
        push(EV_I2, 0, 0, 0);
        push(EV_ERR, 0, 0, 0);
        go(10'h10);
        // R2 fetch starts at start_pc
        check("R2", {22'h0, imem_addr}, 32'h10);
        check("R2", {31'h0, busy}, 32'h1);
        wait_idle();
        step(2);
        // R8 R11 jump reached the undefined word and the block halted
        check("R11", {31'h0, busy}, 32'h0);
        check("R8", exp_q.size(), 32'h0);

        // Program B (R10 R6 R5)
        push(EV_DMA, 32'h3000, 32'h1000 | 32'd8, 32'h55);
        push(EV_ERR, 0, 0, 0);
        dma_ready = 1'b0;
        go(10'h50);
        step(3);
        sync_valid = 1'b1;
        sync_line  = 12'd3;
        step(4);
        // R10 stalled on mismatched line
        check("R10", {22'h0, imem_addr}, 32'h51);
        check("R10", {31'h0, dma_valid}, 32'h0);
        sync_line = 12'd5;
        step();
        sync_valid = 1'b0;
        step(5);
        // R6 request held under back-pressure
        check("R6", {31'h0, dma_valid}, 32'h1);
        check("R6", {20'h0, dma_count}, 32'd8);
        check("R6", dma_addr, 32'h3000);
        step(3);
        check("R6", {31'h0, dma_valid}, 32'h1);
        dma_ready = 1'b1;
        wait_idle();
        step(2);
        check("R10", exp_q.size(), 32'h0);

        // Program C stop loop (R8 R9 R12)
        for (int i = 0; i < 3; i++) begin
            push(EV_REG, 32'h44, 32'h1, 32'h1);
            push(EV_I2, 0, 0, 0);
        end
        go(10'h70);
        step(10);
        // R12 start while busy must not redirect to the undefined word
        start_pc = 10'h30;
        start    = 1'b1;
        step();
        start    = 1'b0;
        for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
        rst_n = 1'b0;
        check("R12", exp_q.size(), 32'h0);
        step(2);
        check("R1", {31'h0, busy}, 32'h0);

        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule